// File: doc/BRIEF.md
# Flash Status and Write-Protect Unit

This unit holds the status byte of a serial flash device and decides, request by request, whether an array program or erase, or a status-register write, may go ahead. The command decoder drives it with one-cycle strobes. These are latch-set, latch-clear, status write with a data byte, and program/erase with a target address and a whole-chip flag. It returns a registered grant or reject pulse one cycle later. The array controller reports the end of an operation with a done pulse. The unit also samples the level of the active-low write-protect pin.

Protection works at two levels. Two region bits choose how much of the top of the array is shielded from program and erase. A lock bit, together with a low write-protect pin, freezes the status register itself. While an array operation runs, the unit refuses every write and lowers a read-allow flag, so that only the status byte can be polled. The decoder sends at most one strobe per cycle.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset the status byte is 0x8C (lock=1, region bits=11, latch=0, busy=0), grant_o and reject_o are 0, and rd_ok_o is 1.
- R2: Status byte layout: bit 0 busy, bit 1 write-enable latch, bit 2 region bit 0, bit 3 region bit 1, bit 7 lock, and bits 6..4 always read 0.
- R3: With busy at 0, a latch-set strobe makes bit 1 read 1 in the next cycle and a latch-clear strobe makes it read 0. While busy is 1, both strobes have no effect.
- R4: A program/erase or status-write strobe arriving while the latch is 0 gives reject_o in the next cycle and changes no status bit.
- R5: Region coding on the two region bits: 00 protects nothing, 01 protects addresses whose two top bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address. A non-chip program/erase to a protected address is rejected and leaves the status byte unchanged.
- R6: A whole-chip erase is granted only when both region bits are 0. Otherwise it is rejected.
- R7: A status write with the latch at 1 is granted when wp_ni is 1 or the lock bit is 0. On a grant, bits 7, 3 and 2 take the data's bits 7, 3 and 2 and the latch clears. When wp_ni is 0 and the lock bit is 1, it is rejected and the status byte stays the same.
- R8: A granted program/erase sets busy and drops rd_ok_o in the next cycle. A done pulse while busy clears both busy and the latch in the next cycle.
- R9: While busy is 1, every program/erase or status-write strobe is rejected.
- R10: grant_o and reject_o are single-cycle pulses, high only in the cycle after a write strobe, and never both high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wren_i | input | 1 | Set write-enable latch strobe |
| wrdi_i | input | 1 | Clear write-enable latch strobe |
| wrsr_i | input | 1 | Status write strobe |
| wrsr_data_i | input | 8 | Status write data |
| pe_req_i | input | 1 | Program/erase request strobe |
| pe_chip_i | input | 1 | Request covers the whole chip |
| pe_addr_i | input | ADDR_W | Target address of the request |
| done_i | input | 1 | Array operation finished |
| wp_ni | input | 1 | Write-protect pin level, active low |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Write request accepted |
| reject_o | output | 1 | Write request refused |
| rd_ok_o | output | 1 | Array read allowed (no operation in progress) |

## Verification
Every output is registered. A strobe or done pulse driven before rising edge N shows up on status_o, grant_o, reject_o and rd_ok_o after that same edge and stays stable until edge N+1. The bench drives inputs on falling edges and compares all four outputs against its behavioural model on every following falling edge. Directed checks read the outputs at the falling edge that ends each one-cycle strobe, which is the first point at which its effect is due. A check made one cycle later then confirms that grant and reject have dropped again.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int STAT_W = 8;
  localparam int B_BUSY = 0;
  localparam int B_WEL  = 1;
  localparam int B_RG0  = 2;
  localparam int B_RG1  = 3;
  localparam int B_LOCK = 7;

  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_GRANT  = 2'd1,
    VERD_REJECT = 2'd2
  } verdict_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] region;
    logic       wel;
    logic       busy;
  } stat_t;

  localparam stat_t STAT_RESET = '{lock: 1'b1, region: 2'b11, wel: 1'b0, busy: 1'b0};

  function automatic logic [STAT_W-1:0] pack_status(stat_t s);
    logic [STAT_W-1:0] b;
    b         = '0;
    b[B_BUSY] = s.busy;
    b[B_WEL]  = s.wel;
    b[B_RG0]  = s.region[0];
    b[B_RG1]  = s.region[1];
    b[B_LOCK] = s.lock;
    return b;
  endfunction
endpackage

// File: rtl/wp_region_check.sv
module wp_region_check #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        region_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              chip_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  logic addr_hit;

  always_comb begin
    unique case (region_i)
      2'b00:   addr_hit = 1'b0;
      2'b01:   addr_hit = &addr_i[TOP -: 2];
      2'b10:   addr_hit = addr_i[TOP];
      default: addr_hit = 1'b1;
    endcase
  end

  // whole-chip erase touches every region
  assign hit_o = chip_i ? (region_i != 2'b00) : addr_hit;
endmodule

// File: rtl/wp_req_decide.sv
module wp_req_decide
  import flash_wp_pkg::*;
(
  input  logic     wren_i,
  input  logic     wrdi_i,
  input  logic     wrsr_i,
  input  logic     pe_req_i,
  input  logic     wp_ni,
  input  logic     hit_i,
  input  stat_t    stat_i,
  output logic     set_wel_o,
  output logic     clr_wel_o,
  output logic     wr_stat_o,
  output logic     start_op_o,
  output verdict_e verdict_o
);
  always_comb begin
    set_wel_o  = 1'b0;
    clr_wel_o  = 1'b0;
    wr_stat_o  = 1'b0;
    start_op_o = 1'b0;
    verdict_o  = VERD_NONE;
    if (stat_i.busy) begin
      if (pe_req_i || wrsr_i) verdict_o = VERD_REJECT;
    end else if (pe_req_i) begin
      if (stat_i.wel && !hit_i) begin
        start_op_o = 1'b1;
        verdict_o  = VERD_GRANT;
      end else begin
        verdict_o  = VERD_REJECT;
      end
    end else if (wrsr_i) begin
      if (stat_i.wel && (wp_ni || !stat_i.lock)) begin
        wr_stat_o = 1'b1;
        verdict_o = VERD_GRANT;
      end else begin
        verdict_o = VERD_REJECT;
      end
    end else if (wrdi_i) begin
      clr_wel_o = 1'b1;
    end else if (wren_i) begin
      set_wel_o = 1'b1;
    end
  end
endmodule

// File: rtl/wp_status_core.sv
module wp_status_core
  import flash_wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              wr_stat_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              start_op_i,
  input  logic              done_i,
  output stat_t             stat_o
);
  stat_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= STAT_RESET;
    end else begin
      if (st_q.busy && done_i) begin
        st_q.busy <= 1'b0;
        st_q.wel  <= 1'b0;
      end
      if (start_op_i) st_q.busy <= 1'b1;
      if (set_wel_i)  st_q.wel  <= 1'b1;
      if (clr_wel_i)  st_q.wel  <= 1'b0;
      if (wr_stat_i) begin
        st_q.region <= {wr_data_i[B_RG1], wr_data_i[B_RG0]};
        st_q.lock   <= wr_data_i[B_LOCK];
        st_q.wel    <= 1'b0;
      end
    end
  end

  assign stat_o = st_q;

  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.busy && done_i) |=> (!st_q.busy && !st_q.wel)); // R8
endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              pe_req_i,
  input  logic              pe_chip_i,
  input  logic [ADDR_W-1:0] pe_addr_i,
  input  logic              done_i,
  input  logic              wp_ni,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              rd_ok_o
);
  stat_t    stat;
  logic     hit;
  logic     set_wel, clr_wel, wr_stat, start_op;
  verdict_e verdict;
  logic     grant_q, reject_q;

  wp_region_check #(.ADDR_W(ADDR_W)) u_region (
    .region_i (stat.region),
    .addr_i   (pe_addr_i),
    .chip_i   (pe_chip_i),
    .hit_o    (hit)
  );

  wp_req_decide u_decide (
    .wren_i     (wren_i),
    .wrdi_i     (wrdi_i),
    .wrsr_i     (wrsr_i),
    .pe_req_i   (pe_req_i),
    .wp_ni      (wp_ni),
    .hit_i      (hit),
    .stat_i     (stat),
    .set_wel_o  (set_wel),
    .clr_wel_o  (clr_wel),
    .wr_stat_o  (wr_stat),
    .start_op_o (start_op),
    .verdict_o  (verdict)
  );

  wp_status_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_wel_i  (set_wel),
    .clr_wel_i  (clr_wel),
    .wr_stat_i  (wr_stat),
    .wr_data_i  (wrsr_data_i),
    .start_op_i (start_op),
    .done_i     (done_i),
    .stat_o     (stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= (verdict == VERD_GRANT);
      reject_q <= (verdict == VERD_REJECT);
    end
  end

  assign status_o = pack_status(stat);
  assign grant_o  = grant_q;
  assign reject_o = reject_q;
  assign rd_ok_o  = ~stat.busy;

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(status_o[B_WEL])); // R4
  AST_PROT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_req_i && hit) |=> reject_o); // R5
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrsr_i && status_o[B_LOCK] && !wp_ni) |=> $stable({status_o[B_LOCK], status_o[B_RG1], status_o[B_RG0]})); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[B_BUSY] && (pe_req_i || wrsr_i)) |=> reject_o); // R9
  AST_NO_GRANT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o); // R10
  AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o)); // R10
endmodule

// File: tb/tb_flash_wp_unit.sv
`timescale 1ns/1ps
module tb_flash_wp_unit;
  localparam int AW    = 17;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren = 0, wrdi = 0, wrsr = 0, pe_req = 0, pe_chip = 0, done = 0, wp_n = 1;
  logic [7:0]    wdata = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0]    status;
  logic          grant, reject, rd_ok;

  int checks = 0, fails = 0;
  bit cmp_en = 0, finished = 0;

  // behavioural reference state
  int m_lock = 1, m_rg = 3, m_wel = 0, m_busy = 0, m_grant = 0, m_reject = 0;

  always #4 clk = ~clk;

  flash_wp_unit #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_data_i(wdata), .pe_req_i(pe_req), .pe_chip_i(pe_chip), .pe_addr_i(addr),
    .done_i(done), .wp_ni(wp_n), .status_o(status), .grant_o(grant),
    .reject_o(reject), .rd_ok_o(rd_ok)
  );

  function automatic bit m_protected(int rg, int a, bit chip);
    if (chip) return rg != 0;
    case (rg)
      0: return 0;
      1: return a >= (DEPTH / 4) * 3;
      2: return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 1; m_rg = 3; m_wel = 0; m_busy = 0; m_grant = 0; m_reject = 0;
    end else begin
      m_grant = 0; m_reject = 0;
      if (m_busy != 0) begin
        if (pe_req || wrsr) m_reject = 1;
        if (done) begin m_busy = 0; m_wel = 0; end
      end else if (pe_req) begin
        if (m_wel != 0 && !m_protected(m_rg, int'(addr), pe_chip)) begin
          m_busy = 1; m_grant = 1;
        end else m_reject = 1;
      end else if (wrsr) begin
        if (m_wel != 0 && (wp_n || m_lock == 0)) begin
          m_rg = int'(wdata[3:2]); m_lock = int'(wdata[7]); m_wel = 0; m_grant = 1;
        end else m_reject = 1;
      end else if (wrdi) m_wel = 0;
      else if (wren) m_wel = 1;
    end
  end

  function automatic logic [7:0] m_status();
    return {m_lock[0], 3'b000, m_rg[1:0], m_wel[0], m_busy[0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 layout, R10 pulses)
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(status == m_status(), "R2 model status", int'(status), int'(m_status()));
      chk(grant == m_grant[0] && reject == m_reject[0], "R10 model verdict",
          int'({grant, reject}), int'({m_grant[0], m_reject[0]}));
      chk(rd_ok == (m_busy == 0), "R8 model rd_ok", int'(rd_ok), int'(m_busy == 0));
    end
  end

  task automatic clr_all();
    wren = 0; wrdi = 0; wrsr = 0; pe_req = 0; pe_chip = 0; done = 0;
  endtask

  task automatic s_wren();  @(negedge clk); wren = 1; @(negedge clk); clr_all(); endtask
  task automatic s_wrdi();  @(negedge clk); wrdi = 1; @(negedge clk); clr_all(); endtask
  task automatic s_done();  @(negedge clk); done = 1; @(negedge clk); clr_all(); endtask
  task automatic s_wrsr(logic [7:0] d);
    @(negedge clk); wrsr = 1; wdata = d; @(negedge clk); clr_all();
  endtask
  task automatic s_pe(int a, bit chip);
    @(negedge clk); pe_req = 1; pe_chip = chip; addr = AW'(a); @(negedge clk); clr_all();
  endtask

  task automatic exp_out(logic [7:0] st, bit g, bit r, string tag);
    chk(status == st, {tag, " status"}, int'(status), int'(st));
    chk(grant == g && reject == r, {tag, " verdict"}, int'({grant, reject}), int'({g, r}));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_en = 1;
    // R1 reset state
    exp_out(8'h8C, 0, 0, "R1");
    chk(rd_ok == 1'b1, "R1 rd_ok", int'(rd_ok), 1);
    // R4 no latch -> reject, no change
    s_pe(0, 0);          exp_out(8'h8C, 0, 1, "R4 pe");
    s_wrsr(8'h00);       exp_out(8'h8C, 0, 1, "R4 wrsr");
    // R3 latch set and clear
    s_wren();            exp_out(8'h8E, 0, 0, "R3 set");
    s_wrdi();            exp_out(8'h8C, 0, 0, "R3 clear");
    // R7 locked with pin low
    wp_n = 0;
    s_wren();
    s_wrsr(8'h00);       exp_out(8'h8E, 0, 1, "R7 locked");
    wp_n = 1;
    s_wrsr(8'h00);       exp_out(8'h00, 1, 0, "R7 unlocked");
    @(negedge clk);      exp_out(8'h00, 0, 0, "R10 pulse ends");
    // R6 chip erase with no protection, R8 busy
    s_wren();
    s_pe(0, 1);          exp_out(8'h03, 1, 0, "R6 chip grant");
    chk(rd_ok == 1'b0, "R8 rd_ok busy", int'(rd_ok), 0);
    // R9 and R3: strobes ignored while busy
    s_pe(0, 0);          exp_out(8'h03, 0, 1, "R9 pe busy");
    s_wrdi();            exp_out(8'h03, 0, 0, "R3 wrdi busy");
    s_done();            exp_out(8'h00, 0, 0, "R8 done");
    // R5 top quarter
    s_wren(); s_wrsr(8'h04);
    s_wren();
    s_pe((DEPTH / 4) * 3, 0); exp_out(8'h06, 0, 1, "R5 quarter hit");
    s_pe(DEPTH / 2, 0);       exp_out(8'h07, 1, 0, "R5 quarter miss");
    s_done();
    // R5 top half, R6 chip with protection
    s_wren(); s_wrsr(8'h08);
    s_wren();
    s_pe(DEPTH / 2, 0);  exp_out(8'h0A, 0, 1, "R5 half hit");
    s_pe(0, 1);          exp_out(8'h0A, 0, 1, "R6 chip protected");
    s_pe(DEPTH / 2 - 1, 0); exp_out(8'h0B, 1, 0, "R5 half miss");
    s_done();
    // R5 whole array
    s_wren(); s_wrsr(8'h0C);
    s_wren();
    s_pe(0, 0);          exp_out(8'h0E, 0, 1, "R5 all hit");
    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      clr_all();
      wp_n  = 1'($urandom_range(0, 3) != 0);
      wdata = 8'($urandom);
      addr  = AW'($urandom);
      case ($urandom_range(0, 7))
        0: wren = 1;
        1: wrdi = 1;
        2: wrsr = 1;
        3: begin pe_req = 1; pe_chip = 1'($urandom_range(0, 3) == 0); end
        4: done = 1;
        5: wren = 1;
        default: ;
      endcase
    end
    @(negedge clk); clr_all();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule